// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block multiplies two 16-bit operands and either keeps the product as the new result or combines it with the result already held. Each operand has its own capture register and its own load strobe. Four mode bits are captured into a mode register whenever either operand strobe fires:

- accumulate enable
- subtract select
- signed select
- round enable

A separate result-load enable then moves the computed value into a 35-bit result register. That result register reads out as three fields: a 3-bit guard extension, a 16-bit high word and a 16-bit low word.

The signed select is chosen at run time. It treats both operands as two's complement or as unsigned magnitude. The three guard bits let a sum of products grow past a single product without losing its sign. Rounding adds one at the most significant bit of the low word, which rounds the high word and the extension.

A preload request, taken on a result-load cycle, writes externally supplied values into any chosen subset of the three fields instead of the arithmetic result. The whole block is synchronous to one clock. The per-register load enables stand in for separate operand and result clocks.

Top module: `mac_unit`

## Requirements
- R1: A synchronous active-high reset clears the operand, mode and result registers, so that all three result fields read zero after reset.
- R2: An operand register changes only when its own strobe (xLoad for X, yLoad for Y) is high. The mode bits are captured only when xLoad or yLoad is high. A result load uses the captured operands and mode bits, not the live inputs.
- R3: With signed select = 1, both operands are two's complement. With signed select = 0, both are unsigned magnitude, and in plain multiply the extension field reads 000.
- R4: With accumulate enable = 0, the result is the product, and the subtract select has no effect.
- R5: With accumulate enable = 1 and subtract select = 0, the result is the product plus the previously held result.
- R6: With accumulate enable = 1 and subtract select = 1, the result is the product minus the previously held result.
- R7: In signed plain multiply, bits 34..31 all equal the product sign. The case -32768 x -32768 gives +2^30: bit 30 set and bits 34..31 clear.
- R8: With round enable = 1, the value 2^15 (bit 15 of the result) is added to the stored value. With round enable = 0, nothing is added.
- R9: The result register changes only on a cycle with resLoad = 1. Otherwise all three fields hold.
- R10: On a cycle with resLoad = 1 and preloadReq = 1, the fields selected by preloadSel are loaded from the preload inputs, and the unselected fields hold. The mapping is preloadSel[2] = extension, preloadSel[1] = high word, preloadSel[0] = low word. The preload replaces the arithmetic result.
- R11: Accumulation wraps modulo 2^35, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xLoad | input | 1 | Capture strobe for the X operand (also captures the mode bits) |
| yLoad | input | 1 | Capture strobe for the Y operand (also captures the mode bits) |
| xIn | input | OP_W | X operand |
| yIn | input | OP_W | Y operand |
| accEn | input | 1 | Accumulate enable |
| subEn | input | 1 | Subtract select (product minus held result) |
| signedEn | input | 1 | Two's complement operands when high |
| roundEn | input | 1 | Add 2^15 when high |
| resLoad | input | 1 | Result register update enable |
| preloadReq | input | 1 | Replace the update with preload data |
| preloadSel | input | 3 | Field select for preload: [2] ext, [1] high, [0] low |
| preExt | input | GUARD_W | Preload value for the extension field |
| preHigh | input | OP_W | Preload value for the high word |
| preLow | input | OP_W | Preload value for the low word |
| extOut | output | GUARD_W | Result bits above the product width |
| highOut | output | OP_W | Result high word |
| lowOut | output | OP_W | Result low word |

## Verification
The bench builds the block with its default parameters: 16-bit operands and 3 guard bits. At these values the full-scale corners can be reached directly: 0xFFFF squared unsigned, -32768 squared signed, and a preload of all ones followed by a +1 product that wraps to zero. The bench splits operand capture from result load so that it can change the mode inputs between the two, and it strobes one operand alone. Both show that only the captured values feed the arithmetic.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic       capX;
    logic       capY;
    logic       capMode;
    logic       updRes;
    logic       preload;
    logic [2:0] preSel;
  } macStrobe_t;

  typedef struct packed {
    logic acc;
    logic sub;
    logic tc;
    logic rnd;
  } macMode_t;

endpackage

// File: rtl/mac_opreg.sv
module mac_opreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);
  always_ff @(posedge clk) begin
    if (rst)       qOut <= '0;
    else if (load) qOut <= dIn;
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xLoad,
  input  logic       yLoad,
  input  logic       accEn,
  input  logic       subEn,
  input  logic       signedEn,
  input  logic       roundEn,
  input  logic       resLoad,
  input  logic       preloadReq,
  input  logic [2:0] preloadSel,
  output macStrobe_t strb,
  output macMode_t   modeQ
);
  logic captureAny;

  always_comb begin
    captureAny   = xLoad | yLoad;
    strb.capX    = xLoad;
    strb.capY    = yLoad;
    strb.capMode = captureAny;
    strb.updRes  = resLoad;
    strb.preload = resLoad & preloadReq;
    strb.preSel  = preloadSel;
  end

  // mode bits share the operand capture event
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= '0;
    end else if (captureAny) begin
      modeQ.acc <= accEn;
      modeQ.sub <= subEn;
      modeQ.tc  <= signedEn;
      modeQ.rnd <= roundEn;
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  macStrobe_t                strb,
  input  macMode_t                  modeQ,
  input  logic [OP_W-1:0]           xIn,
  input  logic [OP_W-1:0]           yIn,
  input  logic [GUARD_W-1:0]        preExt,
  input  logic [OP_W-1:0]           preHigh,
  input  logic [OP_W-1:0]           preLow,
  output logic [2*OP_W+GUARD_W-1:0] resQ
);
  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + GUARD_W;
  localparam int EXT_W  = ACC_W - OP_W;

  logic [OP_W-1:0]  xQ;
  logic [OP_W-1:0]  yQ;
  logic [ACC_W-1:0] xExt;
  logic [ACC_W-1:0] yExt;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] rndAdd;
  logic [ACC_W-1:0] arith;
  logic [ACC_W-1:0] preVec;
  logic [ACC_W-1:0] preMask;
  logic [ACC_W-1:0] resNext;

  mac_opreg #(.W(OP_W)) xReg_i (
    .clk(clk), .rst(rst), .load(strb.capX), .dIn(xIn), .qOut(xQ)
  );
  mac_opreg #(.W(OP_W)) yReg_i (
    .clk(clk), .rst(rst), .load(strb.capY), .dIn(yIn), .qOut(yQ)
  );

  // sign-extend under signed select; the low ACC_W bits of the product
  // are then exact for both number formats
  always_comb begin
    xExt = {{EXT_W{modeQ.tc & xQ[OP_W-1]}}, xQ};
    yExt = {{EXT_W{modeQ.tc & yQ[OP_W-1]}}, yQ};
    prod = xExt * yExt;
  end

  always_comb begin
    rndAdd           = '0;
    rndAdd[OP_W-1]   = modeQ.rnd;
    if (!modeQ.acc)      arith = prod + rndAdd;
    else if (!modeQ.sub) arith = prod + resQ + rndAdd;
    else                 arith = prod - resQ + rndAdd;
  end

  always_comb begin
    preVec  = {preExt, preHigh, preLow};
    preMask = {{GUARD_W{strb.preSel[2]}}, {OP_W{strb.preSel[1]}}, {OP_W{strb.preSel[0]}}};
    if (strb.preload) resNext = (preVec & preMask) | (resQ & ~preMask);
    else              resNext = arith;
  end

  always_ff @(posedge clk) begin
    if (rst)              resQ <= '0;
    else if (strb.updRes) resQ <= resNext;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xLoad,
  input  logic               yLoad,
  input  logic [OP_W-1:0]    xIn,
  input  logic [OP_W-1:0]    yIn,
  input  logic               accEn,
  input  logic               subEn,
  input  logic               signedEn,
  input  logic               roundEn,
  input  logic               resLoad,
  input  logic               preloadReq,
  input  logic [2:0]         preloadSel,
  input  logic [GUARD_W-1:0] preExt,
  input  logic [OP_W-1:0]    preHigh,
  input  logic [OP_W-1:0]    preLow,
  output logic [GUARD_W-1:0] extOut,
  output logic [OP_W-1:0]    highOut,
  output logic [OP_W-1:0]    lowOut
);
  localparam int ACC_W = 2 * OP_W + GUARD_W;

  macStrobe_t       strb;
  macMode_t         modeQ;
  logic [ACC_W-1:0] resQ;

  mac_ctrl ctrl_i (
    .clk(clk), .rst(rst), .xLoad(xLoad), .yLoad(yLoad),
    .accEn(accEn), .subEn(subEn), .signedEn(signedEn), .roundEn(roundEn),
    .resLoad(resLoad), .preloadReq(preloadReq), .preloadSel(preloadSel),
    .strb(strb), .modeQ(modeQ)
  );

  mac_datapath #(.OP_W(OP_W), .GUARD_W(GUARD_W)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .modeQ(modeQ),
    .xIn(xIn), .yIn(yIn), .preExt(preExt), .preHigh(preHigh), .preLow(preLow),
    .resQ(resQ)
  );

  assign extOut  = resQ[ACC_W-1 -: GUARD_W];
  assign highOut = resQ[2*OP_W-1 -: OP_W];
  assign lowOut  = resQ[OP_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               xLoad,
  input logic               yLoad,
  input logic               accEn,
  input logic               signedEn,
  input logic               roundEn,
  input logic               resLoad,
  input logic               preloadReq,
  input logic [2:0]         preloadSel,
  input logic [GUARD_W-1:0] preExt,
  input logic [GUARD_W-1:0] extOut,
  input logic [OP_W-1:0]    highOut,
  input logic [OP_W-1:0]    lowOut
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1
  always @(posedge clk) begin
    if (rstSeen) begin
      reset_clear_chk: assert (extOut == '0 && highOut == '0 && lowOut == '0);
    end
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !resLoad |=> ($stable(extOut) && $stable(highOut) && $stable(lowOut)));

  // R10
  preload_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (resLoad && preloadReq && preloadSel[2]) |=> (extOut == $past(preExt)));

  // R10
  preload_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (resLoad && preloadReq && !preloadSel[0]) |=> $stable(lowOut));

  // R3
  unsigned_ext_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (xLoad && yLoad && !accEn && !signedEn && !roundEn) ##1
    (resLoad && !preloadReq && !xLoad && !yLoad) |=> (extOut == '0));

  // R7
  signed_sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (xLoad && yLoad && !accEn && signedEn && !roundEn) ##1
    (resLoad && !preloadReq && !xLoad && !yLoad)
    |=> ($countones({extOut, highOut[OP_W-1]}) == 0 ||
         $countones({extOut, highOut[OP_W-1]}) == GUARD_W + 1));
endmodule

bind mac_unit mac_unit_chk #(.OP_W(OP_W), .GUARD_W(GUARD_W)) chk_i (
  .clk(clk), .rst(rst), .xLoad(xLoad), .yLoad(yLoad), .accEn(accEn),
  .signedEn(signedEn), .roundEn(roundEn), .resLoad(resLoad),
  .preloadReq(preloadReq), .preloadSel(preloadSel), .preExt(preExt),
  .extOut(extOut), .highOut(highOut), .lowOut(lowOut)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W = 16;
  localparam int GUARD_W = 3;
  localparam int ACC_W = 2 * OP_W + GUARD_W;

  logic clk = 1'b0;
  logic rst;
  logic xLoad, yLoad, accEn, subEn, signedEn, roundEn, resLoad, preloadReq;
  logic [2:0] preloadSel;
  logic [OP_W-1:0] xIn, yIn, preHigh, preLow;
  logic [GUARD_W-1:0] preExt;
  logic [GUARD_W-1:0] extOut;
  logic [OP_W-1:0] highOut, lowOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit #(.OP_W(OP_W), .GUARD_W(GUARD_W)) dut_i (
    .clk(clk), .rst(rst), .xLoad(xLoad), .yLoad(yLoad), .xIn(xIn), .yIn(yIn),
    .accEn(accEn), .subEn(subEn), .signedEn(signedEn), .roundEn(roundEn),
    .resLoad(resLoad), .preloadReq(preloadReq), .preloadSel(preloadSel),
    .preExt(preExt), .preHigh(preHigh), .preLow(preLow),
    .extOut(extOut), .highOut(highOut), .lowOut(lowOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scoreboard
  logic [ACC_W-1:0] expQ[$];
  string tagQ[$];
  bit sbPending = 0;

  // bench model state
  logic [OP_W-1:0] mX = '0, mY = '0;
  bit mAcc = 0, mSub = 0, mTc = 0, mRnd = 0;
  logic [ACC_W-1:0] mHeld = '0;

  function automatic logic [ACC_W-1:0] modelCalc();
    longint xs, ys, p, r;
    logic [63:0] rv;
    xs = mTc ? longint'($signed(mX)) : longint'(mX);
    ys = mTc ? longint'($signed(mY)) : longint'(mY);
    p = xs * ys;
    if (!mAcc)     r = p;
    else if (!mSub) r = p + longint'(mHeld);
    else           r = p - longint'(mHeld);
    if (mRnd) r = r + 32768;
    rv = r;
    return rv[ACC_W-1:0];
  endfunction

  always @(negedge clk) begin
    if (sbPending && expQ.size() > 0) begin
      logic [ACC_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({extOut, highOut, lowOut} !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, {extOut, highOut, lowOut}, e);
      end
      sbPending = 0;
    end
  end

  task automatic capture(bit dx, bit dy, logic [OP_W-1:0] x, logic [OP_W-1:0] y,
                         bit acc, bit sub, bit tc, bit rnd);
    @(negedge clk);
    xLoad = dx; yLoad = dy; xIn = x; yIn = y;
    accEn = acc; subEn = sub; signedEn = tc; roundEn = rnd;
    if (dx) mX = x;
    if (dy) mY = y;
    if (dx || dy) begin mAcc = acc; mSub = sub; mTc = tc; mRnd = rnd; end
    @(posedge clk);
  endtask

  task automatic update(string tag);
    @(negedge clk);
    xLoad = 0; yLoad = 0; resLoad = 1;
    mHeld = modelCalc();
    expQ.push_back(mHeld); tagQ.push_back(tag);
    @(posedge clk);
    sbPending = 1;
    @(negedge clk);
    resLoad = 0;
  endtask

  task automatic preload(logic [2:0] sel, logic [GUARD_W-1:0] e,
                         logic [OP_W-1:0] h, logic [OP_W-1:0] l, string tag);
    @(negedge clk);
    xLoad = 0; yLoad = 0; resLoad = 1; preloadReq = 1; preloadSel = sel;
    preExt = e; preHigh = h; preLow = l;
    if (sel[2]) mHeld[ACC_W-1 -: GUARD_W] = e;
    if (sel[1]) mHeld[2*OP_W-1 -: OP_W] = h;
    if (sel[0]) mHeld[OP_W-1:0] = l;
    expQ.push_back(mHeld); tagQ.push_back(tag);
    @(posedge clk);
    sbPending = 1;
    @(negedge clk);
    resLoad = 0; preloadReq = 0; preloadSel = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; xLoad = 0; yLoad = 0; accEn = 0; subEn = 0; signedEn = 0; roundEn = 0;
    resLoad = 0; preloadReq = 0; preloadSel = '0; xIn = '0; yIn = '0;
    preExt = '0; preHigh = '0; preLow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    checks++;
    if ({extOut, highOut, lowOut} !== '0) begin
      errors++;
      $display("FAIL R1 actual=%h expected=0", {extOut, highOut, lowOut});
    end

    // R3 R4 unsigned full-scale, subtract select ignored in plain multiply
    capture(1, 1, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0);
    update("R3_R4 unsigned FFFFxFFFF");
    // R3 signed -3 x 5
    capture(1, 1, 16'hFFFD, 16'd5, 0, 0, 1, 0);
    update("R3 signed -3x5");
    // R7 most negative squared
    capture(1, 1, 16'h8000, 16'h8000, 0, 0, 1, 0);
    update("R7 -32768x-32768");
    // R5 accumulate add
    capture(1, 1, 16'd100, 16'd200, 1, 0, 0, 0);
    update("R5 accumulate add");
    // R6 product minus held
    capture(1, 1, 16'd7, 16'd9, 1, 1, 1, 0);
    update("R6 product minus held");
    // R2 X strobe alone keeps Y
    capture(1, 0, 16'd3, 16'hAAAA, 0, 0, 0, 0);
    update("R2 X-only strobe");
    // R2 mode inputs change without a strobe: captured mode is used
    @(negedge clk); accEn = 1; subEn = 1; roundEn = 1; signedEn = 1;
    update("R2 mode held without strobe");
    // R8 rounding
    capture(1, 1, 16'd1, 16'd1, 0, 0, 0, 1);
    update("R8 round adds 2^15");
    // R8 round with signed accumulate
    capture(1, 1, 16'hFFFF, 16'd2, 1, 0, 1, 1);
    update("R8 round signed accumulate");
    // R9 idle: no resLoad for several cycles
    @(negedge clk); xIn = 16'h1357; yIn = 16'h2468; accEn = 0;
    repeat (3) @(posedge clk);
    expQ.push_back(mHeld); tagQ.push_back("R9 hold without resLoad");
    sbPending = 1;
    @(negedge clk);
    // R10 partial preload
    preload(3'b101, 3'd5, 16'hBEEF, 16'h1234, "R10 preload ext+low");
    preload(3'b010, 3'd0, 16'hC0DE, 16'hFFFF, "R10 preload high only");
    // R11 wrap
    preload(3'b111, 3'b111, 16'hFFFF, 16'hFFFF, "R10 preload all");
    capture(1, 1, 16'd1, 16'd1, 1, 0, 0, 0);
    update("R11 wrap to zero");
    // R6 after wrap: product minus zero
    capture(1, 1, 16'd4, 16'd4, 1, 1, 0, 0);
    update("R6 minus zero");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule